// File: doc/BRIEF.md
# DMA Logical-to-Physical Address Translator

This block sits between DMA channel engines and the memory system. A channel presents a 24-bit logical address; the block splits it into a 12-bit page index and a 12-bit byte offset. It looks the page up in a four-entry fully associative translation cache and returns a 29-bit physical address made from the cached frame number and the unchanged offset. On a miss it reads the page's frame from a page table in system memory through a one-request read port, installs the frame in the cache and answers the channel.

Software sets the table's physical base address and its size in bytes, and can flush every cached translation with one register write. Each table entry is 8 bytes wide, so the entry for page `p` sits at `base + 8*p`. A page whose entry would lie at or past the size limit is refused. No memory read is made, the channel receives an error, and the logical address is kept in a fault register that software can read.

Top module: `dxl_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `mem_req` are 0, and the base, limit and fault registers all read 0.
- R2: Register select codes: 0 is the table base (bits 28:0, read/write), 1 is the table limit in bytes (32 bits, read/write), 2 is invalidate (write-only, reads 0), and 3 is the fault address (bits 23:0, read-only; writes are ignored). `cfg_rdata` shows the selected register combinationally.
- R3: A request accepted with `8*page >= limit` gives `resp_valid=1`, `resp_err=1` and `resp_paddr=0` in the next cycle. It issues no `mem_req`, and the fault register then holds the request's logical address.
- R4: A miss raises `mem_req` for exactly one cycle, in the cycle after acceptance, with `mem_addr = base + 8*page`. `req_ready` stays 0 until the response.
- R5: In the cycle after `mem_rvalid`, a miss responds with `resp_err=0` and `resp_paddr = {mem_rdata, offset}`, and `req_ready` returns to 1. `mem_rdata` carries physical address bits 28:12 of the entry's frame word.
- R6: A hit responds in the cycle after acceptance, with the cached frame and the offset, and issues no `mem_req`.
- R7: The cache holds four pages. Installs fill the slots in strict rotation. The fifth distinct page evicts the oldest install, and the other three still hit.
- R8: Any write to select code 2 discards every cached translation, so the next access to any page misses.
- R9: If an invalidate write arrives while a fetch is outstanding, the requester still receives that fetch's frame, but the frame is not installed.
- R10: While `req_ready` is 0, `req_valid` is ignored. It produces no response and no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register value |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | 24 | Logical address |
| resp_valid | output | 1 | Response strobe (one cycle) |
| resp_err | output | 1 | Address error |
| resp_paddr | output | 29 | Physical address |
| mem_req | output | 1 | Page-table read request (one cycle) |
| mem_addr | output | 29 | Physical address of the table entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 17 | Frame number from the entry |

## Verification
Logical addresses are driven in several patterns. A first touch of a page shows the fetch path and the entry address. A second touch with another offset shows that a hit forms the address from the cache without a read. Pages on both sides of the limit separate the last legal entry from the first refused one. A sequence of five distinct pages, followed by revisits, shows which slot was replaced. The behavioural table's contents are changed after a flush, and again after an invalidate that overlaps a fetch, so a stale cached frame shows up as a wrong physical address. Requests driven while the block is busy show that `req_valid` is ignored then.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_st_t;

  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_LIMIT = 2'd1;
  localparam logic [1:0] SEL_INVAL = 2'd2;
  localparam logic [1:0] SEL_FAULT = 2'd3;
endpackage

// File: rtl/dxl_rst_sync.sv
module dxl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dxl_cfg_regs.sv
module dxl_cfg_regs
  import dxl_pkg::*;
#(
  parameter int PA_W = 29,
  parameter int LA_W = 24,
  parameter int RW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [RW-1:0]   cfg_wdata,
  output logic [RW-1:0]   cfg_rdata,
  input  logic            fault_we,
  input  logic [LA_W-1:0] fault_addr,
  output logic [PA_W-1:0] base_q,
  output logic [RW-1:0]   limit_q,
  output logic            inval_pulse
);
  logic [PA_W-1:0] base_d;
  logic [RW-1:0]   limit_d;
  logic [LA_W-1:0] fault_q, fault_d;
  logic            base_en, limit_en;
  logic            unused_wdata_hi;

  assign unused_wdata_hi = ^cfg_wdata[RW-1:PA_W];

  assign base_en     = cfg_we && (cfg_sel == SEL_BASE);
  assign limit_en    = cfg_we && (cfg_sel == SEL_LIMIT);
  assign inval_pulse = cfg_we && (cfg_sel == SEL_INVAL);

  always_comb begin
    base_d  = base_en  ? cfg_wdata[PA_W-1:0] : base_q;
    limit_d = limit_en ? cfg_wdata           : limit_q;
    fault_d = fault_we ? fault_addr          : fault_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      fault_q <= '0;
    end else begin
      base_q  <= base_d;
      limit_q <= limit_d;
      fault_q <= fault_d;
    end
  end

  always_comb begin
    case (cfg_sel)
      SEL_BASE:  cfg_rdata = RW'(base_q);
      SEL_LIMIT: cfg_rdata = limit_q;
      SEL_FAULT: cfg_rdata = RW'(fault_q);
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dxl_tlb.sv
module dxl_tlb #(
  parameter int N     = 4,
  parameter int TAG_W = 12,
  parameter int FRM_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [N-1:0]     hit_vec,
  output logic [FRM_W-1:0] hit_frame,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [FRM_W-1:0] fill_frame
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [N];
  logic [TAG_W-1:0] tag_d [N];
  logic [FRM_W-1:0] frm_q [N];
  logic [FRM_W-1:0] frm_d [N];
  logic [IDX_W-1:0] rr_q, rr_d;

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    for (int i = 0; i < N; i++) begin
      tag_d[i] = tag_q[i];
      frm_d[i] = frm_q[i];
    end
    if (flush) begin
      vld_d = '0;
    end else if (fill_en) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == rr_q) begin
          vld_d[i] = 1'b1;
          tag_d[i] = fill_tag;
          frm_d[i] = fill_frame;
        end
      end
      rr_d = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      tag_q[i] <= tag_d[i];
      frm_q[i] <= frm_d[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    hit_frame = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_frame = hit_frame | frm_q[i];
    end
  end
endmodule

// File: rtl/dxl_walker.sv
module dxl_walker
  import dxl_pkg::*;
#(
  parameter int LA_W = 24,
  parameter int PA_W = 29,
  parameter int PG_B = 12,
  parameter int RW   = 32,
  localparam int TAG_W = LA_W - PG_B,
  localparam int FRM_W = PA_W - PG_B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  output logic             resp_valid,
  output logic             resp_err,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [FRM_W-1:0] mem_rdata,
  input  logic [PA_W-1:0]  base_q,
  input  logic [RW-1:0]    limit_q,
  input  logic             inval_pulse,
  output logic [TAG_W-1:0] lk_tag,
  input  logic             hit,
  input  logic [FRM_W-1:0] hit_frame,
  output logic             fill_en,
  output logic [TAG_W-1:0] fill_tag,
  output logic [FRM_W-1:0] fill_frame,
  output logic             fault_we,
  output logic [LA_W-1:0]  fault_addr
);
  localparam int OFF_W = TAG_W + 3;

  walk_st_t        st_q, st_d;
  logic            rv_q, rv_d, re_q, re_d, mr_q, mr_d;
  logic [PA_W-1:0] pa_q, pa_d, ma_q, ma_d;
  logic [LA_W-1:0] lat_q, lat_d;
  logic            stale_q, stale_d;

  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] ent_off;
  logic             accept, oob;

  assign req_tag = req_laddr[LA_W-1:PG_B];
  assign ent_off = {req_tag, 3'b000};
  assign oob     = RW'(ent_off) >= limit_q;
  assign accept  = req_valid && (st_q == ST_IDLE);

  assign lk_tag     = req_tag;
  assign fill_tag   = lat_q[LA_W-1:PG_B];
  assign fill_frame = mem_rdata;
  assign fault_addr = req_laddr;
  assign fault_we   = accept && oob;
  assign fill_en    = (st_q == ST_WAIT) && mem_rvalid && !stale_q && !inval_pulse;

  always_comb begin
    st_d    = st_q;
    rv_d    = 1'b0;
    re_d    = 1'b0;
    mr_d    = 1'b0;
    pa_d    = pa_q;
    ma_d    = ma_q;
    lat_d   = lat_q;
    stale_d = stale_q | inval_pulse;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (oob) begin
            rv_d = 1'b1;
            re_d = 1'b1;
            pa_d = '0;
          end else if (hit) begin
            rv_d = 1'b1;
            pa_d = {hit_frame, req_laddr[PG_B-1:0]};
          end else begin
            st_d    = ST_WAIT;
            mr_d    = 1'b1;
            ma_d    = base_q + PA_W'(ent_off);
            lat_d   = req_laddr;
            stale_d = 1'b0;
          end
        end
      end
      default: begin
        if (mem_rvalid) begin
          st_d = ST_IDLE;
          rv_d = 1'b1;
          pa_d = {mem_rdata, lat_q[PG_B-1:0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rv_q    <= 1'b0;
      re_q    <= 1'b0;
      mr_q    <= 1'b0;
      pa_q    <= '0;
      ma_q    <= '0;
      lat_q   <= '0;
      stale_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rv_q    <= rv_d;
      re_q    <= re_d;
      mr_q    <= mr_d;
      pa_q    <= pa_d;
      ma_q    <= ma_d;
      lat_q   <= lat_d;
      stale_q <= stale_d;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign resp_valid = rv_q;
  assign resp_err   = re_q;
  assign resp_paddr = pa_q;
  assign mem_req    = mr_q;
  assign mem_addr   = ma_q;
endmodule

// File: rtl/dxl_xlate.sv
module dxl_xlate #(
  parameter int LA_W = 24,
  parameter int PA_W = 29,
  parameter int PG_B = 12,
  parameter int RW   = 32,
  parameter int N    = 4,
  localparam int TAG_W = LA_W - PG_B,
  localparam int FRM_W = PA_W - PG_B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [RW-1:0]    cfg_wdata,
  output logic [RW-1:0]    cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  output logic             resp_valid,
  output logic             resp_err,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [FRM_W-1:0] mem_rdata
);
  logic             rst_n_sync;
  logic [PA_W-1:0]  base_q;
  logic [RW-1:0]    limit_q;
  logic             inval_pulse;
  logic             fault_we;
  logic [LA_W-1:0]  fault_addr;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic [N-1:0]     hit_vec;
  logic [FRM_W-1:0] hit_frame, fill_frame;
  logic             hit, fill_en;

  dxl_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  dxl_cfg_regs #(.PA_W(PA_W), .LA_W(LA_W), .RW(RW)) u_cfg (
    .clk(clk), .rst_n(rst_n_sync),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fault_we(fault_we), .fault_addr(fault_addr),
    .base_q(base_q), .limit_q(limit_q), .inval_pulse(inval_pulse)
  );

  dxl_tlb #(.N(N), .TAG_W(TAG_W), .FRM_W(FRM_W)) u_tlb (
    .clk(clk), .rst_n(rst_n_sync), .flush(inval_pulse),
    .lk_tag(lk_tag), .hit_vec(hit_vec), .hit_frame(hit_frame),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_frame(fill_frame)
  );

  assign hit = |hit_vec;

  dxl_walker #(.LA_W(LA_W), .PA_W(PA_W), .PG_B(PG_B), .RW(RW)) u_walk (
    .clk(clk), .rst_n(rst_n_sync),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_paddr(resp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .base_q(base_q), .limit_q(limit_q), .inval_pulse(inval_pulse),
    .lk_tag(lk_tag), .hit(hit), .hit_frame(hit_frame),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_frame(fill_frame),
    .fault_we(fault_we), .fault_addr(fault_addr)
  );
endmodule

// File: rtl/dxl_chk.sv
module dxl_chk #(
  parameter int LA_W = 24,
  parameter int PG_B = 12,
  parameter int RW   = 32,
  parameter int N    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [LA_W-1:0] req_laddr,
  input logic [RW-1:0]   limit_q,
  input logic            mem_req,
  input logic            mem_rvalid,
  input logic            resp_valid,
  input logic            resp_err,
  input logic            inval_pulse,
  input logic [N-1:0]    hit_vec
);
  // R3
  oob_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (RW'({req_laddr[LA_W-1:PG_B], 3'b000}) >= limit_q))
      |=> (resp_valid && resp_err && !mem_req));

  // R4
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4
  busy_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R5
  fetch_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && mem_rvalid) |=> (resp_valid && !resp_err && req_ready));

  // R7
  unique_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |=> (hit_vec == '0));
endmodule

bind dxl_xlate dxl_chk #(.LA_W(LA_W), .PG_B(PG_B), .RW(RW), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_laddr(req_laddr), .limit_q(limit_q), .mem_req(mem_req),
  .mem_rvalid(mem_rvalid), .resp_valid(resp_valid), .resp_err(resp_err),
  .inval_pulse(inval_pulse), .hit_vec(hit_vec)
);

// File: tb/sim_dxl_xlate.sv
module sim_dxl_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_laddr = '0;
  logic        resp_valid, resp_err;
  logic [28:0] resp_paddr;
  logic        mem_req;
  logic [28:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [16:0] mem_rdata = '0;

  int tests = 0;
  int fails = 0;
  int salt = 0;
  int nreq = 0;
  int mwait = 0;
  logic [28:0] maddr = '0;
  logic [28:0] base_v = 29'h0010_0000;
  logic [29:0] expq [$];

  always #5 clk = ~clk;

  dxl_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_laddr(req_laddr), .resp_valid(resp_valid),
    .resp_err(resp_err), .resp_paddr(resp_paddr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [16:0] frame_of(input int idx);
    return 17'(idx * 7 + 3 + salt * 1000);
  endfunction

  function automatic logic [28:0] pa_of(input logic [23:0] la);
    return {frame_of(int'(la[23:12])), la[11:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural page table: 3-cycle read latency
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (mwait > 0) begin
      mwait--;
      if (mwait == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = frame_of(int'((maddr - base_v) >> 3));
      end
    end
    if (mem_req) begin
      maddr = mem_addr;
      mwait = 3;
      nreq++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R10 unexpected response", longint'(resp_paddr), 0);
      end else begin
        logic [29:0] e;
        e = expq.pop_front();
        chk({resp_err, resp_paddr} == e, "R3/R5/R6 response", longint'({resp_err, resp_paddr}), longint'(e));
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] sel, output logic [31:0] d);
    cfg_sel = sel;
    #1;
    d = cfg_rdata;
  endtask

  task automatic send(input logic [23:0] la, input bit err);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_laddr = la;
    expq.push_back(err ? {1'b1, 29'd0} : {1'b0, pa_of(la)});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(resp_valid == 1'b0 && mem_req == 1'b0, "R1 idle outputs", {resp_valid, mem_req}, 0);
    cfg_rd(2'd0, rd); chk(rd == 0, "R1 base", rd, 0);
    cfg_rd(2'd1, rd); chk(rd == 0, "R1 limit", rd, 0);
    cfg_rd(2'd3, rd); chk(rd == 0, "R1 fault", rd, 0);

    // R2 register map
    cfg_wr(2'd0, {3'b0, base_v});
    cfg_wr(2'd1, 32'h400);
    cfg_wr(2'd3, 32'h00AB_CDEF);
    cfg_rd(2'd0, rd); chk(rd == {3'b0, base_v}, "R2 base readback", rd, base_v);
    cfg_rd(2'd1, rd); chk(rd == 32'h400, "R2 limit readback", rd, 32'h400);
    cfg_rd(2'd3, rd); chk(rd == 0, "R2 fault not writable", rd, 0);
    cfg_rd(2'd2, rd); chk(rd == 0, "R2 invalidate reads zero", rd, 0);

    // R4/R5 miss on page 5
    n0 = nreq;
    send(24'h005123, 1'b0);
    chk(req_ready == 1'b0, "R4 busy during fetch", req_ready, 0);
    drain();
    chk(nreq == n0 + 1, "R4 one read", nreq - n0, 1);
    chk(maddr == base_v + 29'd40, "R4 entry address", maddr, base_v + 29'd40);

    // R6 hit on page 5, other offset
    n0 = nreq;
    send(24'h005FFF, 1'b0);
    chk(resp_valid == 1'b1, "R6 hit latency", resp_valid, 1);
    drain();
    chk(nreq == n0, "R6 no read on hit", nreq - n0, 0);

    // R3 limit boundary
    n0 = nreq;
    send(24'h080010, 1'b1);
    drain();
    chk(nreq == n0, "R3 no read on error", nreq - n0, 0);
    cfg_rd(2'd3, rd); chk(rd == 32'h080010, "R3 fault captured", rd, 32'h080010);
    send(24'h07F004, 1'b0);
    drain();
    chk(nreq == n0 + 1, "R3 last legal page fetched", nreq - n0, 1);

    // R7 round robin: slots hold 5,127; fill 1,2; page 3 evicts 5
    send(24'h001000, 1'b0); drain();
    send(24'h002000, 1'b0); drain();
    send(24'h003000, 1'b0); drain();
    n0 = nreq;
    send(24'h07F800, 1'b0); drain();
    chk(nreq == n0, "R7 survivor hits", nreq - n0, 0);
    send(24'h005010, 1'b0); drain();
    chk(nreq == n0 + 1, "R7 oldest evicted", nreq - n0, 1);
    n0 = nreq;
    send(24'h001234, 1'b0); drain();
    chk(nreq == n0, "R7 page 1 kept", nreq - n0, 0);

    // R8 flush then table change
    cfg_wr(2'd2, 32'h0);
    salt = 1;
    n0 = nreq;
    send(24'h001234, 1'b0); drain();
    chk(nreq == n0 + 1, "R8 miss after flush", nreq - n0, 1);

    // R9 invalidate during fetch
    send(24'h009100, 1'b0);
    cfg_wr(2'd2, 32'h0);
    drain();
    salt = 2;
    n0 = nreq;
    send(24'h009200, 1'b0); drain();
    chk(nreq == n0 + 1, "R9 not installed", nreq - n0, 1);

    // R10 request while busy is ignored
    n0 = nreq;
    send(24'h00A000, 1'b0);
    req_valid = 1'b1; req_laddr = 24'h00B000;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    chk(nreq == n0 + 1, "R10 no extra read", nreq - n0, 1);
    n0 = nreq;
    send(24'h00B000, 1'b0); drain();
    chk(nreq == n0 + 1, "R10 busy page not cached", nreq - n0, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule